// File: doc/BRIEF.md
# Split Dual 8-bit Auto-Reload Timer

This block is a timer that always runs as two separate 8-bit up-counters, an upper half and a lower half. Each half has its own reload register, its own run bit and its own count-source selector. A half advances by one on each cycle where the clock-enable strobe it has selected is high. When a half steps past its maximum value, it loads its reload value again. Strobes are generated outside the block. The upper half picks from eight strobes and the lower half picks from four.

Three sticky event flags are kept. The upper-wrap flag can be masked by an ignore bit. The lower-wrap flag has its own interrupt enable. The external flag is set by a falling edge on an asynchronous trigger pin. The lower half's wrap is also sent out as a one-cycle event pulse for other peripherals. A chain-stop option makes an upper wrap clear the lower half's run bit. A remap bit sets what two control-register bit positions mean: either two clock-select outputs, or the lower-wrap flag and its enable.

Software uses a simple register port. A write takes effect on the clock edge. A read returns the addressed register one cycle after the address is presented.

Top module: `split_reload_timer`

## Requirements
- R1: A half holds its count unless its run bit is 1 and its selected strobe is high. When both are true, it adds one on that clock edge.
- R2: When a half advances while at its all-ones value, it loads its reload register instead of wrapping to zero.
- R3: Field SRC[2:0] selects which of hi_ce[7:0] drives the upper half. Field SRC[5:4] selects which of lo_ce[3:0] drives the lower half. A strobe on any input that is not selected has no effect.
- R4: When MODE[1] (chain stop) is 1, an upper-half wrap clears the lower run bit MODE[0]. This hardware clear wins over a software write in the same cycle.
- R5: An upper wrap sets the upper flag CTRL[7] unless the ignore bit MODE[2] is 1. With the ignore bit set, the reload still happens. irq_hi follows the upper flag.
- R6: A lower wrap sets the lower flag. irq_lo is high only when both the lower flag and the lower enable are set.
- R7: ext_in passes through a two-flop synchronizer. A high-to-low transition sets the external flag CTRL[6], and irq_ext follows it. A rising edge has no effect.
- R8: Flags are sticky and hardware never clears them. Writing 0 to a flag's CTRL position clears it, and writing 1 leaves it unchanged. If hardware sets a flag in the same cycle that software clears it, the flag ends up set.
- R9: ovf_pulse goes high for exactly one cycle, in the cycle after each lower-half wrap. An upper wrap never raises it.
- R10: When MODE[3] is 0, CTRL bits 5 and 4 write and read rx_clk_sel and tx_clk_sel. When MODE[3] is 1, bit 5 is the lower flag (clear by writing 0) and bit 4 is the lower enable.
- R11: After reset, every register reads 0 and all outputs are 0.
- R12: The register map is as follows. Address 0 is CTRL, with CTRL[2] as the upper run bit. Address 1 is MODE. Address 2 is SRC. Address 3 is the upper count and address 4 is the lower count; software writes to these load the count. Address 5 is the upper reload and address 6 is the lower reload. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_ce | input | HI_SRCS | Clock-enable strobes available to the upper half |
| lo_ce | input | LO_SRCS | Clock-enable strobes available to the lower half |
| ext_in | input | 1 | Asynchronous external trigger, active on falling edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | CNT_W | Registered read data |
| irq_hi | output | 1 | Upper wrap flag |
| irq_lo | output | 1 | Lower wrap flag gated by its enable |
| irq_ext | output | 1 | External edge flag |
| ovf_pulse | output | 1 | One-cycle pulse per lower wrap |
| rx_clk_sel | output | 1 | Receive clock-select bit |
| tx_clk_sel | output | 1 | Transmit clock-select bit |

## Verification
The bench builds the block with its defaults: 8-bit halves, eight upper strobes and four lower strobes. Each select field therefore has room for both selected and unselected inputs. Because the count registers can be written directly, a wrap can be reached in one or two strobes rather than 256. This makes the reload, the flag, the chain-stop and the same-cycle set-versus-clear cases quick to reach.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_MODE   = 3'd1,
    A_SRC    = 3'd2,
    A_HI_CNT = 3'd3,
    A_LO_CNT = 3'd4,
    A_HI_RLD = 3'd5,
    A_LO_RLD = 3'd6
  } reg_addr_e;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/srt_edge_sync.sv
module srt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              synced;

  assign synced = chain_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      prev_q  <= synced;
    end
  end

  assign fall = prev_q & ~synced;

  // R7: a detected edge means the previous synchronized level was high
  a_r7_fall_from_high: assert property (@(posedge clk) disable iff (rst)
    fall |-> $past(synced));
endmodule

// File: rtl/srt_counter.sv
module srt_counter #(
  parameter int unsigned W    = 8,
  parameter int unsigned NSRC = 8,
  localparam int unsigned SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [NSRC-1:0] ce,
  input  logic [SELW-1:0] sel,
  input  logic            load,
  input  logic [W-1:0]    load_val,
  input  logic [W-1:0]    reload,
  output logic [W-1:0]    cnt,
  output logic            wrap
);
  logic strobe;
  logic tick;

  always_comb begin
    strobe = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SELW'(i)) strobe = ce[i];
    end
  end

  assign tick = run & strobe & ~load;
  assign wrap = tick & (&cnt);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= wrap ? reload : cnt + 1'b1;
  end

  // R1: with no advance and no load the count is frozen
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt));
  // R2: a wrap lands on the reload value
  a_r2_reload: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == $past(reload)));
endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned HI_SRCS = 8,
  parameter int unsigned LO_SRCS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HI_SRCS-1:0] hi_ce,
  input  logic [LO_SRCS-1:0] lo_ce,
  input  logic               ext_in,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [2:0]         rd_addr,
  output logic [CNT_W-1:0]   rd_data,
  output logic               irq_hi,
  output logic               irq_lo,
  output logic               irq_ext,
  output logic               ovf_pulse,
  output logic               rx_clk_sel,
  output logic               tx_clk_sel
);
  import srt_pkg::*;

  localparam int unsigned HSW = (HI_SRCS > 1) ? $clog2(HI_SRCS) : 1;
  localparam int unsigned LSW = (LO_SRCS > 1) ? $clog2(LO_SRCS) : 1;

  logic             hi_run, lo_run, chain_stop, hi_ign, alt_sel, lo_ie;
  logic             hi_flag, lo_flag, ext_flag;
  logic [HSW-1:0]   hi_sel;
  logic [LSW-1:0]   lo_sel;
  logic [CNT_W-1:0] hi_rld, lo_rld, hi_cnt, lo_cnt;
  logic             hi_wrap, lo_wrap, ext_fall;
  logic             ctrl_wr, hi_load, lo_load;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign hi_load = wr_en && (wr_addr == A_HI_CNT);
  assign lo_load = wr_en && (wr_addr == A_LO_CNT);

  srt_counter #(.W(CNT_W), .NSRC(HI_SRCS)) u_hi (
    .clk(clk), .rst(rst), .run(hi_run), .ce(hi_ce), .sel(hi_sel),
    .load(hi_load), .load_val(wr_data), .reload(hi_rld),
    .cnt(hi_cnt), .wrap(hi_wrap));

  srt_counter #(.W(CNT_W), .NSRC(LO_SRCS)) u_lo (
    .clk(clk), .rst(rst), .run(lo_run), .ce(lo_ce), .sel(lo_sel),
    .load(lo_load), .load_val(wr_data), .reload(lo_rld),
    .cnt(lo_cnt), .wrap(lo_wrap));

  srt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(ext_in), .fall(ext_fall));

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= 1'b0; lo_run <= 1'b0; chain_stop <= 1'b0; hi_ign <= 1'b0;
      alt_sel <= 1'b0; lo_ie <= 1'b0; rx_clk_sel <= 1'b0; tx_clk_sel <= 1'b0;
      hi_sel <= '0; lo_sel <= '0; hi_rld <= '0; lo_rld <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_CTRL: begin
            hi_run <= wr_data[2];
            if (alt_sel) lo_ie <= wr_data[4];
            else begin
              rx_clk_sel <= wr_data[5];
              tx_clk_sel <= wr_data[4];
            end
          end
          A_MODE: begin
            lo_run     <= wr_data[0];
            chain_stop <= wr_data[1];
            hi_ign     <= wr_data[2];
            alt_sel    <= wr_data[3];
          end
          A_SRC: begin
            hi_sel <= wr_data[HSW-1:0];
            lo_sel <= wr_data[4 +: LSW];
          end
          A_HI_RLD: hi_rld <= wr_data;
          A_LO_RLD: lo_rld <= wr_data;
          default: ;
        endcase
      end
      if (hi_wrap && chain_stop) lo_run <= 1'b0;
    end
  end

  // sticky flags: hardware set wins over a software clear
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_flag <= 1'b0; lo_flag <= 1'b0; ext_flag <= 1'b0; ovf_pulse <= 1'b0;
    end else begin
      hi_flag  <= (hi_wrap & ~hi_ign) | (hi_flag & ~(ctrl_wr & ~wr_data[7]));
      ext_flag <= ext_fall | (ext_flag & ~(ctrl_wr & ~wr_data[6]));
      lo_flag  <= lo_wrap | (lo_flag & ~(ctrl_wr & alt_sel & ~wr_data[5]));
      ovf_pulse <= lo_wrap;
    end
  end

  assign irq_hi  = hi_flag;
  assign irq_ext = ext_flag;
  assign irq_lo  = lo_flag & lo_ie;

  // registered read port
  logic [CNT_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_mux[7] = hi_flag;
        rd_mux[6] = ext_flag;
        rd_mux[5] = alt_sel ? lo_flag : rx_clk_sel;
        rd_mux[4] = alt_sel ? lo_ie : tx_clk_sel;
        rd_mux[2] = hi_run;
      end
      A_MODE: begin
        rd_mux[0] = lo_run;
        rd_mux[1] = chain_stop;
        rd_mux[2] = hi_ign;
        rd_mux[3] = alt_sel;
      end
      A_SRC: begin
        rd_mux[HSW-1:0]  = hi_sel;
        rd_mux[4 +: LSW] = lo_sel;
      end
      A_HI_CNT: rd_mux = hi_cnt;
      A_LO_CNT: rd_mux = lo_cnt;
      A_HI_RLD: rd_mux = hi_rld;
      A_LO_RLD: rd_mux = lo_rld;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // R4: chained stop halts the lower half
  a_r4_chain_stop: assert property (@(posedge clk) disable iff (rst)
    (hi_wrap && chain_stop) |=> !lo_run);
  // R5: ignore bit keeps the upper flag clear
  a_r5_ignore: assert property (@(posedge clk) disable iff (rst)
    (hi_wrap && hi_ign && !hi_flag) |=> !irq_hi);
  // R8: flag holds unless a clearing write arrives
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (hi_flag && !(ctrl_wr && !wr_data[7])) |=> irq_hi);
  // R8: set wins against a same-cycle clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (lo_wrap && ctrl_wr) |=> lo_flag);
  // R9: event pulse follows each lower wrap, one cycle
  a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
    lo_wrap |=> ovf_pulse);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> $past(lo_wrap));
  // R6: gated request needs the enable
  a_r6_gate: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> lo_ie);
endmodule

// File: tb/split_reload_timer_bench.sv
module split_reload_timer_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] hi_ce;
  logic [3:0] lo_ce;
  logic       ext_in;
  logic       wr_en;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       irq_hi, irq_lo, irq_ext, ovf_pulse, rx_clk_sel, tx_clk_sel;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  split_reload_timer u_split_reload_timer (
    .clk(clk), .rst(rst), .hi_ce(hi_ce), .lo_ce(lo_ce), .ext_in(ext_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_hi(irq_hi), .irq_lo(irq_lo), .irq_ext(irq_ext),
    .ovf_pulse(ovf_pulse), .rx_clk_sel(rx_clk_sel), .tx_clk_sel(tx_clk_sel));

  always @(posedge clk) if (!rst && ovf_pulse) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic pulse_hi(input int idx);
    @(negedge clk); hi_ce[idx] = 1'b1;
    @(negedge clk); hi_ce = '0;
  endtask

  task automatic pulse_lo(input int idx);
    @(negedge clk); lo_ce[idx] = 1'b1;
    @(negedge clk); lo_ce = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R11 reg", v, 0);
    end
    chk("R11 irqs", {irq_hi, irq_lo, irq_ext, ovf_pulse, rx_clk_sel, tx_clk_sel}, 0);
  endtask

  task automatic t_hi_count();
    logic [7:0] v;
    wr(3'd2, 8'h23);   // R12 SRC: upper src 3, lower src 2
    wr(3'd0, 8'h04);   // upper run
    for (int i = 0; i < 5; i++) pulse_hi(3);
    rd(3'd3, v); chk("R1 count", v, 5);
    for (int i = 0; i < 3; i++) pulse_hi(2);
    rd(3'd3, v); chk("R3 unselected hi", v, 5);
  endtask

  task automatic t_hi_wrap();
    logic [7:0] v;
    wr(3'd3, 8'hFE); wr(3'd5, 8'h40);
    pulse_hi(3); pulse_hi(3);
    rd(3'd3, v); chk("R2 reload", v, 8'h40);
    chk("R5 flag", irq_hi, 1);
    chk("R9 no hi pulse", pulses, 0);
    wr(3'd0, 8'h04);
    chk("R8 clear", irq_hi, 0);
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    wr(3'd1, 8'h04); wr(3'd3, 8'hFF);
    pulse_hi(3);
    rd(3'd3, v); chk("R5 ignore reload", v, 8'h40);
    chk("R5 ignore flag", irq_hi, 0);
  endtask

  task automatic t_lo();
    logic [7:0] v;
    wr(3'd1, 8'h09);   // lower run, remap on
    wr(3'd0, 8'h14);   // upper run, lower enable
    wr(3'd4, 8'hFF); wr(3'd6, 8'h10);
    pulse_lo(2);
    rd(3'd4, v); chk("R2 lo reload", v, 8'h10);
    chk("R9 lo pulse", pulses, 1);
    chk("R6 irq_lo", irq_lo, 1);
    pulse_lo(1);
    rd(3'd4, v); chk("R3 unselected lo", v, 8'h10);
    wr(3'd0, 8'h04);   // clear lower flag, enable off
    chk("R8 lo clear", irq_lo, 0);
    wr(3'd4, 8'hFF); pulse_lo(2);
    chk("R6 gated", irq_lo, 0);
    rd(3'd0, v); chk("R6 flag visible", v, 8'h24);
  endtask

  task automatic t_remap();
    logic [7:0] v;
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h34);
    chk("R10 clk sel", {rx_clk_sel, tx_clk_sel}, 2'b11);
    rd(3'd0, v); chk("R10 read sel", v, 8'h34);
    wr(3'd1, 8'h09);
    rd(3'd0, v); chk("R10 read flag", v, 8'h24);
  endtask

  task automatic t_chain();
    logic [7:0] v;
    wr(3'd1, 8'h0B);
    wr(3'd3, 8'hFF);
    pulse_hi(3);
    rd(3'd1, v); chk("R4 lo_run cleared", v, 8'h0A);
    wr(3'd4, 8'h33); pulse_lo(2);
    rd(3'd4, v); chk("R4 lo halted", v, 8'h33);
    chk("R9 pulses", pulses, 2);
  endtask

  task automatic t_ext();
    logic [7:0] v;
    wr(3'd0, 8'h04);
    ext_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 fall", irq_ext, 1);
    wr(3'd0, 8'h04);
    chk("R8 ext clear", irq_ext, 0);
    ext_in = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 rise ignored", irq_ext, 0);
  endtask

  task automatic t_race();
    wr(3'd3, 8'hFF);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h04; hi_ce[3] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; hi_ce = '0;
    chk("R8 set wins", irq_hi, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; hi_ce = '0; lo_ce = '0; ext_in = 1'b1;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_hi_count();
    t_hi_wrap();
    t_ignore();
    t_lo();
    t_remap();
    t_chain();
    t_ext();
    t_race();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule